// File: doc/BRIEF.md
# Bursty Hotspot Cell Traffic Generator

This block produces fixed-length cell arrivals for a single input port of an N-port switch, one decision per discrete time slot. A two-state burst process (idle or active) decides whether a cell leaves in a slot. While active, a cell is emitted in every slot. In each active slot the burst may end with one programmable probability. In each idle slot a new burst may start with a second programmable probability. Both period lengths are therefore geometrically distributed. The package supplies suggested probability constants for a mean active length of about 1200 slots and a mean idle length of about 800 slots.

Each emitted cell carries a destination port index. A programmable skew factor selects between the hot-port set and the full port range. At skew 0 the destinations are uniform over all N ports. At full scale every cell goes to a hot port. Values in between mix the two distributions in proportion. Within the chosen set the destination is uniform, drawn by rejection sampling, so set sizes that are not a power of two work too. All randomness comes from internal 16-bit LFSRs seeded from an input when reset is released. Two slot counters, one for active slots and one for idle slots, let a bench estimate the mean burst lengths.

Top module: `cell_traffic_gen`

## Requirements
- R1: While reset is held and after it is released, `cell_vld_o`, `on_o`, `on_slots_o` and `off_slots_o` are all 0.
- R2: `cell_vld_o` is 1 in the cycle after a slot strobe exactly when `on_o` was 1 before that strobe, and is 0 in every cycle that does not follow a strobe.
- R3: With `p_start_i` = 16'hFFFF an idle slot always moves the state to active (`on_o` = 1 after the strobe). With `p_start_i` = 0 the state never leaves idle. With `p_end_i` = 0 an active burst never ends.
- R4: With `p_end_i` = 16'hFFFF an active burst lasts exactly one slot, so with `p_start_i` = 16'hFFFF as well, cells appear in every second slot.
- R5: Each strobe adds 1 to `on_slots_o` if the state before it was active, and to `off_slots_o` otherwise. Their sum equals the number of strobes since reset.
- R6: With `skew_i` = 0, destinations are spread uniformly over all N ports.
- R7: With `skew_i` = 16'hFFFF and a non-empty `hot_mask_i`, every destination is a port whose mask bit (bit i = port i) is 1.
- R8: An all-zero `hot_mask_i` is treated as all ports being hot.
- R9: Within a hot set of a size that is not a power of two (for example 3 ports), destinations are uniform over its members.
- R10: The probability that a cell goes to a hot port is s + (1 − s)·k/N, where s = `skew_i`/65535 and k is the number of hot ports.
- R11: The probability of ending a burst per active slot is `p_end_i`/65535, and the probability of starting one per idle slot is `p_start_i`/65535. The mean burst length is therefore 65535/`p_end_i` slots.
- R12: The same seed gives the same cell sequence after every reset. A different seed gives a different sequence.
- R13: Cycles without a slot strobe change neither the state, the counters nor the outputs, and `cell_vld_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seed_i | input | 16 | Seed, loaded in the first clock after reset is released |
| slot_i | input | 1 | Slot strobe, one slot per high cycle |
| p_end_i | input | 16 | Burst end probability per active slot, fraction of 65535 |
| p_start_i | input | 16 | Burst start probability per idle slot, fraction of 65535 |
| skew_i | input | 16 | Hot-port skew factor, fraction of 65535 |
| hot_mask_i | input | N_PORTS | Hot port set, bit i = port i |
| cell_vld_o | output | 1 | A cell was emitted for the last slot |
| cell_dst_o | output | $clog2(N_PORTS) | Destination port of that cell |
| on_o | output | 1 | Burst state: 1 active, 0 idle |
| on_slots_o | output | 32 | Slots spent in the active state |
| off_slots_o | output | 32 | Slots spent in the idle state |

## Verification
Every result of a slot is due one clock after the rising edge that samples the strobe. At that point `cell_vld_o`, `cell_dst_o`, `on_o` and both counters have all moved together, with no further pipeline stage. The seed load takes the first clock after reset is released, so every scenario waits two clocks before its first strobe. The bench drives the strobe on a falling edge, reads `on_o` just before it, and reads all results at the next falling edge, which is exactly one register stage later. Distribution and mean-length checks collect a few thousand slots and compare the counts against bounds several standard deviations wide.

// File: rtl/cell_gen_pkg.sv
package cell_gen_pkg;
  localparam int          RAND_W     = 16;
  localparam logic [15:0] LFSR_POLY  = 16'hB400;
  // suggested probabilities: mean active ~1200 slots, mean idle ~800 slots
  localparam logic [15:0] DEF_P_END   = 16'd55;
  localparam logic [15:0] DEF_P_START = 16'd82;

  typedef enum logic {ST_IDLE = 1'b0, ST_ACTIVE = 1'b1} burst_st_e;

  function automatic logic [RAND_W-1:0] seed_salt(input int idx);
    return RAND_W'((idx + 1) * 40503);
  endfunction
endpackage

// File: rtl/cg_lfsr.sv
module cg_lfsr #(
  parameter int              W     = 16,
  parameter logic [W-1:0]    POLY  = 16'hB400,
  parameter int              STEPS = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] st_q, st_nxt;

  // several Galois steps per slot to decorrelate consecutive draws
  always_comb begin
    st_nxt = st_q;
    for (int s = 0; s < STEPS; s++)
      st_nxt = st_nxt[0] ? ((st_nxt >> 1) ^ POLY) : (st_nxt >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      st_q <= W'(1);
    else if (load_i)  st_q <= (seed_i == '0) ? W'(1) : seed_i;
    else if (adv_i)   st_q <= st_nxt;
  end

  assign state_o = st_q;

  assert_lfsr_alive_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0);
endmodule

// File: rtl/cg_burst_fsm.sv
module cg_burst_fsm
  import cell_gen_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_en_i,
  input  logic [RAND_W-1:0] draw_i,
  input  logic [RAND_W-1:0] p_end_i,
  input  logic [RAND_W-1:0] p_start_i,
  output logic              on_o,
  output logic [CNT_W-1:0]  on_slots_o,
  output logic [CNT_W-1:0]  off_slots_o
);
  burst_st_e st_q, st_d;
  logic [CNT_W-1:0] on_cnt_q, off_cnt_q;

  always_comb begin
    st_d = st_q;
    if (slot_en_i) begin
      if (st_q == ST_ACTIVE) begin
        if (draw_i < p_end_i) st_d = ST_IDLE;
      end else begin
        if (draw_i < p_start_i) st_d = ST_ACTIVE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      on_cnt_q  <= '0;
      off_cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (slot_en_i) begin
        if (st_q == ST_ACTIVE) on_cnt_q  <= on_cnt_q + 1'b1;
        else                   off_cnt_q <= off_cnt_q + 1'b1;
      end
    end
  end

  assign on_o        = (st_q == ST_ACTIVE);
  assign on_slots_o  = on_cnt_q;
  assign off_slots_o = off_cnt_q;

  assert_idle_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_en_i |=> $stable(on_o) && $stable(on_slots_o) && $stable(off_slots_o));
  assert_end_certain_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_en_i && on_o && p_end_i == 16'hFFFF) |=> !on_o);
  assert_start_never_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_en_i && !on_o && p_start_i == '0) |=> !on_o);
endmodule

// File: rtl/cg_dst_sel.sv
module cg_dst_sel #(
  parameter int N_PORTS = 16,
  parameter int PW      = 4,
  parameter int TRIES   = 8,
  parameter int POOL_W  = 32
) (
  input  logic               use_hot_i,
  input  logic [N_PORTS-1:0] hot_mask_i,
  input  logic [POOL_W-1:0]  pool_i,
  output logic [PW-1:0]      dst_o,
  output logic [N_PORTS-1:0] set_o
);
  localparam int KW = $clog2(N_PORTS + 1);

  logic [KW-1:0] k, rmask, seen, rank;
  logic [PW-1:0] cand;
  logic          found;

  always_comb begin
    set_o = (use_hot_i && (|hot_mask_i)) ? hot_mask_i : '1;
    k = '0;
    for (int i = 0; i < N_PORTS; i++) k = k + KW'(set_o[i]);
    // smallest all-ones mask covering k-1
    rmask = k - 1'b1;
    for (int b = 0; b < KW; b++) rmask = rmask | (rmask >> 1);
    // parallel rejection tries, first accepted wins
    found = 1'b0;
    rank  = '0;
    cand  = '0;
    for (int t = 0; t < TRIES; t++) begin
      cand = pool_i[t*PW +: PW] & rmask[PW-1:0];
      if (!found && (KW'(cand) < k)) begin
        rank  = KW'(cand);
        found = 1'b1;
      end
    end
    if (!found) rank = KW'(cand) - k;
    // map rank to the rank-th member of the set
    dst_o = '0;
    seen  = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (set_o[i]) begin
        if (seen == rank) dst_o = PW'(i);
        seen = seen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cell_traffic_gen.sv
module cell_traffic_gen
  import cell_gen_pkg::*;
#(
  parameter int N_PORTS = 16,
  parameter int TRIES   = 8,
  parameter int CNT_W   = 32,
  localparam int PW     = $clog2(N_PORTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [15:0]        seed_i,
  input  logic               slot_i,
  input  logic [15:0]        p_end_i,
  input  logic [15:0]        p_start_i,
  input  logic [15:0]        skew_i,
  input  logic [N_PORTS-1:0] hot_mask_i,
  output logic               cell_vld_o,
  output logic [PW-1:0]      cell_dst_o,
  output logic               on_o,
  output logic [CNT_W-1:0]   on_slots_o,
  output logic [CNT_W-1:0]   off_slots_o
);
  localparam int CAND_BITS = TRIES * PW;
  localparam int N_CAND    = (CAND_BITS + RAND_W - 1) / RAND_W;
  localparam int N_LFSR    = 2 + N_CAND;
  localparam int POOL_W    = N_CAND * RAND_W;

  logic              load_q, slot_en, use_hot;
  logic [RAND_W-1:0] lfsr_st [N_LFSR];
  logic [RAND_W-1:0] draw_burst, draw_hot;
  logic [POOL_W-1:0] pool;
  logic [PW-1:0]     sel_dst;
  logic [N_PORTS-1:0] sel_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b1;
    else         load_q <= 1'b0;
  end

  assign slot_en = slot_i & ~load_q;

  for (genvar g = 0; g < N_LFSR; g++) begin : g_lfsr
    cg_lfsr #(.W(RAND_W), .POLY(LFSR_POLY), .STEPS(RAND_W)) u_lfsr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load_q),
      .adv_i   (slot_en),
      .seed_i  (seed_i ^ seed_salt(g)),
      .state_o (lfsr_st[g])
    );
  end

  for (genvar c = 0; c < N_CAND; c++) begin : g_pool
    assign pool[c*RAND_W +: RAND_W] = lfsr_st[2+c];
  end

  // draws span 0..65534, so 0 never hits and 16'hFFFF always hits
  assign draw_burst = lfsr_st[0] - 1'b1;
  assign draw_hot   = lfsr_st[1] - 1'b1;
  assign use_hot    = draw_hot < skew_i;

  cg_burst_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_en_i   (slot_en),
    .draw_i      (draw_burst),
    .p_end_i     (p_end_i),
    .p_start_i   (p_start_i),
    .on_o        (on_o),
    .on_slots_o  (on_slots_o),
    .off_slots_o (off_slots_o)
  );

  cg_dst_sel #(.N_PORTS(N_PORTS), .PW(PW), .TRIES(TRIES), .POOL_W(POOL_W)) u_dst (
    .use_hot_i  (use_hot),
    .hot_mask_i (hot_mask_i),
    .pool_i     (pool),
    .dst_o      (sel_dst),
    .set_o      (sel_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cell_vld_o <= 1'b0;
      cell_dst_o <= '0;
    end else begin
      cell_vld_o <= slot_en & on_o;
      if (slot_en && on_o) cell_dst_o <= sel_dst;
    end
  end

  assert_dst_in_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_set[sel_dst]);
  assert_vld_after_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_vld_o |-> $past(slot_i));
  assert_cnt_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_en |=> CNT_W'(on_slots_o + off_slots_o) ==
                CNT_W'($past(on_slots_o) + $past(off_slots_o) + 1));
endmodule

// File: tb/cell_traffic_gen_tb.sv
module cell_traffic_gen_tb;
  localparam int N  = 16;
  localparam int PW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [15:0]   seed_i = 16'h1234;
  logic          slot_i = 1'b0;
  logic [15:0]   p_end_i = '0, p_start_i = '0, skew_i = '0;
  logic [N-1:0]  hot_mask_i = '0;
  logic          cell_vld_o, on_o;
  logic [PW-1:0] cell_dst_o;
  logic [31:0]   on_slots_o, off_slots_o;

  int n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  cell_traffic_gen #(.N_PORTS(N)) u_dut (
    .clk_i, .rst_ni, .seed_i, .slot_i, .p_end_i, .p_start_i, .skew_i,
    .hot_mask_i, .cell_vld_o, .cell_dst_o, .on_o, .on_slots_o, .off_slots_o
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [15:0] pe, ps, sk, input logic [N-1:0] hm);
    p_end_i = pe; p_start_i = ps; skew_i = sk; hot_mask_i = hm;
  endtask

  task automatic do_reset(input logic [15:0] seed);
    @(negedge clk_i);
    rst_ni = 1'b0; seed_i = seed; slot_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  // one slot: strobe at a falling edge, results read one clock later
  task automatic slot_once(output bit v, output logic [PW-1:0] d, output bit w);
    w = on_o;
    slot_i = 1'b1;
    @(negedge clk_i);
    slot_i = 1'b0;
    v = cell_vld_o;
    d = cell_dst_o;
  endtask

  task automatic t_reset;
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    check(!cell_vld_o && !on_o, "R1 outputs in reset", {cell_vld_o, on_o}, 0);
    check(on_slots_o == 0 && off_slots_o == 0, "R1 counters in reset", on_slots_o + off_slots_o, 0);
    cfg(16'h1000, 16'h1000, 16'h0, 16'h00FF);
    do_reset(16'h1234);
    check(!cell_vld_o && !on_o && on_slots_o == 0 && off_slots_o == 0, "R1 after release",
          {cell_vld_o, on_o}, 0);
  endtask

  task automatic t_fixed_start;
    bit v, w; logic [PW-1:0] d; int bad = 0;
    do_reset(16'h0BAD);
    cfg(16'h0, 16'hFFFF, 16'h0, '0);
    slot_once(v, d, w);
    check(!v && on_o, "R3 idle slot starts burst", {v, on_o}, 1);
    for (int i = 0; i < 20; i++) begin
      slot_once(v, d, w);
      if (!v || !on_o) bad++;
    end
    check(bad == 0, "R3 burst never ends with p_end 0", bad, 0);
  endtask

  task automatic t_never_start;
    bit v, w; logic [PW-1:0] d; int bad = 0;
    do_reset(16'h7777);
    cfg(16'hFFFF, 16'h0, 16'h0, '0);
    for (int i = 0; i < 50; i++) begin
      slot_once(v, d, w);
      if (v || on_o) bad++;
    end
    check(bad == 0, "R3 no start with p_start 0", bad, 0);
  endtask

  task automatic t_alternate;
    bit v, w; logic [PW-1:0] d; int bad = 0;
    do_reset(16'h5A5A);
    cfg(16'hFFFF, 16'hFFFF, 16'h0, '0);
    for (int i = 0; i < 30; i++) begin
      slot_once(v, d, w);
      if (v != (i % 2 == 1)) bad++;
    end
    check(bad == 0, "R4 single-slot bursts alternate", bad, 0);
  endtask

  task automatic t_idle;
    bit v, w; logic [PW-1:0] d; int bad = 0;
    logic [31:0] on0, off0;
    do_reset(16'h3141);
    cfg(16'h0, 16'hFFFF, 16'h0, '0);
    slot_once(v, d, w);
    slot_once(v, d, w);
    on0 = on_slots_o; off0 = off_slots_o;
    cfg(16'hFFFF, 16'hFFFF, 16'h0, '0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (cell_vld_o || !on_o) bad++;
    end
    check(bad == 0, "R13 no cell and state held without strobe", bad, 0);
    check(on_slots_o == on0 && off_slots_o == off0, "R13 counters held",
          on_slots_o + off_slots_o, on0 + off0);
  endtask

  task automatic t_uniform;
    bit v, w; logic [PW-1:0] d; int cnt[N]; int bad = 0, worst = 0;
    do_reset(16'hC0DE);
    cfg(16'h0, 16'hFFFF, 16'h0, 16'h000F);
    foreach (cnt[i]) cnt[i] = 0;
    slot_once(v, d, w);
    for (int i = 0; i < 3200; i++) begin
      slot_once(v, d, w);
      if (v != w) bad++;
      if (v) cnt[d]++;
    end
    check(bad == 0, "R2 valid follows prior state", bad, 0);
    foreach (cnt[i]) if (cnt[i] < 120 || cnt[i] > 280) worst++;
    check(worst == 0, "R6 uniform spread over all ports", worst, 0);
  endtask

  task automatic t_hot_only;
    bit v, w; logic [PW-1:0] d; int cnt[N]; int outside = 0, off_band = 0;
    logic [N-1:0] hm = 16'h0824; // ports 2, 5, 11
    do_reset(16'hBEEF);
    cfg(16'h0, 16'hFFFF, 16'hFFFF, hm);
    foreach (cnt[i]) cnt[i] = 0;
    slot_once(v, d, w);
    for (int i = 0; i < 3000; i++) begin
      slot_once(v, d, w);
      if (v) begin cnt[d]++; if (!hm[d]) outside++; end
    end
    check(outside == 0, "R7 only hot destinations at full skew", outside, 0);
    foreach (cnt[i]) if (hm[i] && (cnt[i] < 880 || cnt[i] > 1120)) off_band++;
    check(off_band == 0, "R9 uniform in 3-port hot set", off_band, 0);
  endtask

  task automatic t_empty_mask;
    bit v, w; logic [PW-1:0] d; int cnt[N]; int missing = 0;
    do_reset(16'h2468);
    cfg(16'h0, 16'hFFFF, 16'hFFFF, '0);
    foreach (cnt[i]) cnt[i] = 0;
    slot_once(v, d, w);
    for (int i = 0; i < 1600; i++) begin
      slot_once(v, d, w);
      if (v) cnt[d]++;
    end
    foreach (cnt[i]) if (cnt[i] < 40) missing++;
    check(missing == 0, "R8 empty mask reaches every port", missing, 0);
  endtask

  task automatic t_mix;
    bit v, w; logic [PW-1:0] d; int hot = 0;
    do_reset(16'h1357);
    cfg(16'h0, 16'hFFFF, 16'h8000, 16'h00FF);
    slot_once(v, d, w);
    for (int i = 0; i < 4000; i++) begin
      slot_once(v, d, w);
      if (v && d < 8) hot++;
    end
    check(hot > 2850 && hot < 3150, "R10 hot fraction near 0.75", hot, 3000);
  endtask

  task automatic t_burst_mean;
    bit v, w; logic [PW-1:0] d; int cells = 0, bursts = 0, bad = 0;
    do_reset(16'hACE1);
    cfg(16'd8191, 16'd8191, 16'h0, '0);
    for (int i = 0; i < 8000; i++) begin
      slot_once(v, d, w);
      if (v != w) bad++;
      if (v) cells++;
      if (!w && on_o) bursts++;
    end
    check(bad == 0, "R2 valid follows prior state in bursts", bad, 0);
    check(on_slots_o == cells && off_slots_o == 8000 - cells, "R5 slot counters",
          on_slots_o, cells);
    check(bursts > 0 && cells * 10 > bursts * 65 && cells * 10 < bursts * 95,
          "R11 mean burst length near 8 (x10)", bursts > 0 ? cells * 10 / bursts : 0, 80);
  endtask

  task automatic record(input logic [15:0] seed, output logic [PW:0] sig [64]);
    bit v, w; logic [PW-1:0] d;
    do_reset(seed);
    cfg(16'h4000, 16'h4000, 16'h8000, 16'h00F0);
    for (int i = 0; i < 64; i++) begin
      slot_once(v, d, w);
      sig[i] = {v, v ? d : '0};
    end
  endtask

  task automatic t_seed;
    logic [PW:0] a [64], b [64], c [64]; int diff_ab = 0, diff_ac = 0;
    record(16'h1234, a);
    record(16'h1234, b);
    record(16'h4321, c);
    for (int i = 0; i < 64; i++) begin
      if (a[i] != b[i]) diff_ab++;
      if (a[i] != c[i]) diff_ac++;
    end
    check(diff_ab == 0, "R12 same seed repeats", diff_ab, 0);
    check(diff_ac > 0, "R12 other seed differs", diff_ac, 1);
  endtask

  initial begin
    #2_000_000ns;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed_start();
    t_never_start();
    t_alternate();
    t_idle();
    t_uniform();
    t_hot_only();
    t_empty_mask();
    t_mix();
    t_burst_mean();
    t_seed();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule